// File: doc/BRIEF.md
# Serial DAC Host Frame Generator

This block is the host-side controller for a dual-channel 8-bit serial DAC. It takes one request at a time on a valid/ready command port. A request can select the reference, write channel A, write channel B, stage a channel B value in the holding register, update both channels together, or power the converter down. For each request the block builds the 16-bit word or words that the converter expects. It then sends them on an active-low chip select, a serial clock and a data line.

Each half-period of the serial clock lasts `HALF_CYC` system-clock cycles. The integrator picks this value so that the converter's minimum clock high time, clock low time, setup time and hold time are all met at the system clock rate. A simultaneous update is sent as two frames. The first frame puts the channel B code into the holding register only. The second frame writes channel A, and that write also moves the held value into channel B, so both outputs change together. A busy flag covers the whole sequence. A one-cycle done pulse marks its end.

Top module: `dac_frame_gen`

## Requirements
- R1: After reset and between commands, chip select and serial clock are both high, `cmd_ready_o` is high, `busy_o` is low and `done_o` is low.
- R2: A frame carries 16 bits, most significant bit first. The data line changes only at a rising serial clock edge or at the chip select falling edge, so it is stable across each falling edge.
- R3: Each serial clock high phase and low phase lasts `HALF_CYC` cycles. Chip select is low for at least `HALF_CYC` cycles before the first falling edge. At least `HALF_CYC` cycles pass after the 16th falling edge before chip select rises. Chip select stays high for at least `HALF_CYC` cycles between two frames.
- R4: Every chip select low window contains exactly 16 falling serial clock edges.
- R5: Reference select (op 0) sends bit15=1, bit14=speed, bit13=0, bit12=1, bits 11..2 zero and bits 1..0 set to the requested reference code (10 selects the high internal level and 01 the low one).
- R6: Write A (op 1) sends bits 15..12 = {1,speed,0,0}. Write B (op 2) sends {0,speed,0,0}. Stage B (op 3) sends {0,speed,0,1}. In each case the 8-bit code sits in bits 11..4 and bits 3..0 are zero.
- R7: Update both (op 4) sends two frames: first the stage-B word with the B code, then the write-A word with the A code.
- R8: Power down (op 5) sends bit13=1, bit14=speed and all other bits zero.
- R9: A command is accepted only when `cmd_ready_o` is high. `cmd_ready_o` stays low from acceptance until chip select has been high for `HALF_CYC` cycles after the last frame. A request presented while busy produces no frame.
- R10: `done_o` is a single-cycle pulse one cycle after chip select rises at the end of the last frame. No pulse follows the first frame of an update.
- R11: Op codes 6 and 7 are accepted but send no frame, and `done_o` pulses in the cycle after acceptance.
- R12: The speed bit (bit14) follows `cmd_fast_i` in every frame, including both frames of an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Controller can accept a command |
| cmd_op_i | input | 3 | Operation: 0 ref, 1 write A, 2 write B, 3 stage B, 4 update both, 5 power down |
| cmd_code_a_i | input | 8 | Channel A code |
| cmd_code_b_i | input | 8 | Channel B code |
| cmd_ref_i | input | 2 | Reference select code |
| cmd_fast_i | input | 1 | Speed bit placed in every frame |
| busy_o | output | 1 | Inverse of ready |
| done_o | output | 1 | End-of-sequence pulse |
| dac_cs_no | output | 1 | Chip select, active low |
| dac_sclk_o | output | 1 | Serial clock, idles high |
| dac_sdo_o | output | 1 | Serial data to the converter |

## Verification
The assertions assume that command fields only matter in the cycle where valid and ready are both high. They also assume that the shifter is started only by the sequencer, and only while the shifter is idle. The stimulus always waits for ready before it raises valid, and it drops valid one cycle after acceptance. The one exception is the busy test, which raises valid on purpose while a frame is in progress, to show that nothing gets through. All command fields stay constant while valid is high. Reset is applied only at the start, so the timing properties never see an interrupted frame.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
  localparam int unsigned FRAME_W   = 16;
  localparam int unsigned PAYLOAD_W = 12;

  typedef enum logic [2:0] {
    OP_SET_REF     = 3'd0,
    OP_WRITE_A     = 3'd1,
    OP_WRITE_B     = 3'd2,
    OP_STAGE_B     = 3'd3,
    OP_UPDATE_BOTH = 3'd4,
    OP_POWER_DOWN  = 3'd5
  } dac_op_e;

  // register-select pair, split over bit15 (hi) and bit12 (lo)
  typedef enum logic [1:0] {
    SEL_B_AND_HOLD = 2'b00,
    SEL_HOLD_ONLY  = 2'b01,
    SEL_A_XFER     = 2'b10,
    SEL_CONTROL    = 2'b11
  } dac_sel_e;

  typedef logic [FRAME_W-1:0] frame_t;

  function automatic frame_t pack_frame(dac_sel_e sel, logic fast, logic pwr,
                                        logic [PAYLOAD_W-1:0] payload);
    return {sel[1], fast, pwr, sel[0], payload};
  endfunction
endpackage

// File: rtl/dac_word_builder.sv
module dac_word_builder
  import dac_frame_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  input  logic [1:0]        ref_i,
  input  logic              fast_i,
  output frame_t            word0_o,
  output frame_t            word1_o,
  output logic [1:0]        nfrm_o
);
  localparam int unsigned PAD = PAYLOAD_W - CODE_W;

  logic [PAYLOAD_W-1:0] pay_a, pay_b, pay_ref;

  assign pay_a   = PAYLOAD_W'(code_a_i) << PAD;
  assign pay_b   = PAYLOAD_W'(code_b_i) << PAD;
  assign pay_ref = PAYLOAD_W'(ref_i);

  always_comb begin
    word0_o = '0;
    word1_o = '0;
    nfrm_o  = 2'd1;
    case (dac_op_e'(op_i))
      OP_SET_REF:     word0_o = pack_frame(SEL_CONTROL, fast_i, 1'b0, pay_ref);
      OP_WRITE_A:     word0_o = pack_frame(SEL_A_XFER, fast_i, 1'b0, pay_a);
      OP_WRITE_B:     word0_o = pack_frame(SEL_B_AND_HOLD, fast_i, 1'b0, pay_b);
      OP_STAGE_B:     word0_o = pack_frame(SEL_HOLD_ONLY, fast_i, 1'b0, pay_b);
      OP_UPDATE_BOTH: begin
        word0_o = pack_frame(SEL_HOLD_ONLY, fast_i, 1'b0, pay_b);
        word1_o = pack_frame(SEL_A_XFER, fast_i, 1'b0, pay_a);
        nfrm_o  = 2'd2;
      end
      OP_POWER_DOWN:  word0_o = pack_frame(SEL_B_AND_HOLD, fast_i, 1'b1, '0);
      default:        nfrm_o  = 2'd0;
    endcase
  end
endmodule

// File: rtl/dac_serial_shifter.sv
module dac_serial_shifter
  import dac_frame_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  frame_t word_i,
  output logic   idle_o,
  output logic   cs_rise_o,
  output logic   cs_no,
  output logic   sclk_o,
  output logic   sdo_o
);
  localparam int unsigned HC_W   = $clog2(HALF_CYC + 1);
  localparam int unsigned GAP_PH = 2 * FRAME_W + 1;
  localparam int unsigned PH_W   = $clog2(GAP_PH + 1);

  logic            act_q, cs_q, sclk_q, rise_q, half_end;
  logic [HC_W-1:0] hc_q;
  logic [PH_W-1:0] ph_q, ph_nx;
  frame_t          sh_q;

  assign half_end = (hc_q == HC_W'(HALF_CYC - 1));
  assign ph_nx    = ph_q + 1'b1;

  // phase 0: setup, odd: sclk low, even: sclk high, GAP_PH: cs high recovery
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      hc_q   <= '0;
      ph_q   <= '0;
      sh_q   <= '0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (start_i && !act_q) begin
        act_q  <= 1'b1;
        hc_q   <= '0;
        ph_q   <= '0;
        sh_q   <= word_i;
        cs_q   <= 1'b0;
        sclk_q <= 1'b1;
      end else if (act_q) begin
        if (!half_end) begin
          hc_q <= hc_q + 1'b1;
        end else begin
          hc_q <= '0;
          if (ph_q == PH_W'(GAP_PH)) begin
            act_q <= 1'b0;
          end else begin
            ph_q <= ph_nx;
            if (ph_nx == PH_W'(GAP_PH)) begin
              cs_q   <= 1'b1;
              rise_q <= 1'b1;
            end else if (ph_nx[0]) begin
              sclk_q <= 1'b0;
            end else begin
              sclk_q <= 1'b1;
              sh_q   <= sh_q << 1;
            end
          end
        end
      end
    end
  end

  assign idle_o    = !act_q;
  assign cs_rise_o = rise_q;
  assign cs_no     = cs_q;
  assign sclk_o    = sclk_q;
  assign sdo_o     = sh_q[FRAME_W-1];

  p_start_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> idle_o);
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (cs_no && sclk_o));
  p_sclk_fall_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (!cs_no && !$past(cs_no)));
  p_cs_rise_sclk_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (sclk_o && $past(sclk_o)));
  p_sdo_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no) && !$rose(sclk_o)) |-> $stable(sdo_o));
endmodule

// File: rtl/dac_cmd_seq.sv
module dac_cmd_seq
  import dac_frame_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  frame_t     word0_i,
  input  frame_t     word1_i,
  input  logic [1:0] nfrm_i,
  input  logic       sh_idle_i,
  input  logic       sh_cs_rise_i,
  output logic       start_o,
  output frame_t     word_o,
  output logic       done_o
);
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} seq_st_e;

  seq_st_e st_q;
  frame_t  cur_q, nxt_q;
  logic    more_q, done_q, accept;

  assign cmd_ready_o = (st_q == S_IDLE) && sh_idle_i;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign start_o     = (st_q == S_LAUNCH) && sh_idle_i;
  assign word_o      = cur_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      nxt_q  <= '0;
      more_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          if (nfrm_i == 2'd0) begin
            done_q <= 1'b1;
          end else begin
            cur_q  <= word0_i;
            nxt_q  <= word1_i;
            more_q <= (nfrm_i == 2'd2);
            st_q   <= S_LAUNCH;
          end
        end
        S_LAUNCH: if (sh_idle_i) st_q <= S_WAIT;
        S_WAIT: if (sh_cs_rise_i) begin
          if (more_q) begin
            cur_q  <= nxt_q;
            more_q <= 1'b0;
            st_q   <= S_LAUNCH;
          end else begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_accept_moves_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((st_q != S_IDLE) || done_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_q == S_IDLE));
endmodule

// File: rtl/dac_frame_gen.sv
module dac_frame_gen
  import dac_frame_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8,
  parameter int unsigned CODE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [CODE_W-1:0] cmd_code_a_i,
  input  logic [CODE_W-1:0] cmd_code_b_i,
  input  logic [1:0]        cmd_ref_i,
  input  logic              cmd_fast_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dac_cs_no,
  output logic              dac_sclk_o,
  output logic              dac_sdo_o
);
  frame_t     word0, word1, sh_word;
  logic [1:0] nfrm;
  logic       sh_idle, sh_rise, sh_start;

  dac_word_builder #(.CODE_W(CODE_W)) u_build (
    .op_i     (cmd_op_i),
    .code_a_i (cmd_code_a_i),
    .code_b_i (cmd_code_b_i),
    .ref_i    (cmd_ref_i),
    .fast_i   (cmd_fast_i),
    .word0_o  (word0),
    .word1_o  (word1),
    .nfrm_o   (nfrm)
  );

  dac_cmd_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .word0_i      (word0),
    .word1_i      (word1),
    .nfrm_i       (nfrm),
    .sh_idle_i    (sh_idle),
    .sh_cs_rise_i (sh_rise),
    .start_o      (sh_start),
    .word_o       (sh_word),
    .done_o       (done_o)
  );

  dac_serial_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (sh_start),
    .word_i    (sh_word),
    .idle_o    (sh_idle),
    .cs_rise_o (sh_rise),
    .cs_no     (dac_cs_no),
    .sclk_o    (dac_sclk_o),
    .sdo_o     (dac_sdo_o)
  );

  assign busy_o = !cmd_ready_o;

  p_done_cs_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dac_cs_no && $past(dac_cs_no)));
  p_busy_while_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_cs_no |-> busy_o);
endmodule

// File: tb/sim_dac_frame_gen.sv
module sim_dac_frame_gen;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [7:0] code_a = '0, code_b = '0;
  logic [1:0] ref_sel = '0;
  logic       fast = 1'b0;
  logic       busy, done, cs_n, sclk, sdo;

  dac_frame_gen #(.HALF_CYC(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_code_a_i(code_a), .cmd_code_b_i(code_b),
    .cmd_ref_i(ref_sel), .cmd_fast_i(fast), .busy_o(busy), .done_o(done),
    .dac_cs_no(cs_n), .dac_sclk_o(sclk), .dac_sdo_o(sdo)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // passive line monitor, samples at negedge
  int          cyc = 0, nfr = 0, n_csfall = 0, ndone = 0, done_cyc = 0, rise_cyc = -100000;
  logic [15:0] fr_word [64];
  int          fr_falls[64], fr_setup[64], fr_hold[64], fr_minrun[64], fr_gap[64];
  logic [15:0] cur = '0;
  int          nfalls = 0, cs_fall_cyc = 0, last_fall_cyc = 0, run = 0, minrun = 0;
  logic        pcs = 1'b1, psclk = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (pcs && !cs_n) begin
        cur = '0; nfalls = 0; cs_fall_cyc = cyc; minrun = 1000000;
        if (nfr < 64) fr_gap[nfr] = cyc - rise_cyc;
        n_csfall = n_csfall + 1;
      end
      if (sclk != psclk) begin
        if (!cs_n && !pcs && (psclk == 1'b0 || nfalls > 0) && run < minrun) minrun = run;
        run = 1;
      end else run = run + 1;
      if (!cs_n && psclk && !sclk) begin
        cur = {cur[14:0], sdo};
        nfalls = nfalls + 1;
        if (nfalls == 1) fr_setup[nfr] = cyc - cs_fall_cyc;
        last_fall_cyc = cyc;
      end
      if (!pcs && cs_n && nfr < 64) begin
        fr_word[nfr] = cur; fr_falls[nfr] = nfalls; fr_hold[nfr] = cyc - last_fall_cyc;
        fr_minrun[nfr] = minrun; rise_cyc = cyc; nfr = nfr + 1;
      end
      if (done) begin ndone = ndone + 1; done_cyc = cyc; end
    end
    pcs = cs_n; psclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [1:0] r, input logic f);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; code_a = a; code_b = b; ref_sel = r; fast = f;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int lim = 4000;
    while (ndone == d0 && lim > 0) begin @(posedge clk); lim--; end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_cmd(input string tag, input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [1:0] r, input logic f,
                         input int exp_n, input logic [15:0] e0, input logic [15:0] e1);
    int base = nfr;
    int d0 = ndone;
    issue(op, a, b, r, f);
    wait_done(d0);
    chk(nfr - base == exp_n, {tag, " frame count"}, nfr - base, exp_n);
    chk(fr_word[base] == e0, {tag, " word0"}, fr_word[base], e0);
    chk(fr_falls[base] == 16, "R4 falls per frame", fr_falls[base], 16);
    if (exp_n == 2) begin
      chk(fr_word[base+1] == e1, {tag, " word1"}, fr_word[base+1], e1);
      chk(fr_falls[base+1] == 16, "R4 falls per frame", fr_falls[base+1], 16);
      chk(fr_gap[base+1] >= HALF, "R3 inter-frame cs high", fr_gap[base+1], HALF);
    end
    chk(ndone - d0 == 1, "R10 one done pulse", ndone - d0, 1);
    chk(done_cyc == rise_cyc + 1, "R10 done timing", done_cyc - rise_cyc, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n && sclk, "R1 idle lines", {cs_n, sclk}, 2'b11);
    chk(cmd_ready && !busy && !done, "R1 ready/busy/done", {cmd_ready, busy, done}, 3'b100);
  endtask

  task automatic t_set_ref;
    run_cmd("R5 ref high", 3'd0, 8'h00, 8'h00, 2'b10, 1'b1, 1, 16'hD002, 16'h0);
    run_cmd("R5 ref low", 3'd0, 8'hFF, 8'hFF, 2'b01, 1'b0, 1, 16'h9001, 16'h0);
  endtask

  task automatic t_writes;
    run_cmd("R6 write A", 3'd1, 8'hA5, 8'h00, 2'b00, 1'b0, 1, 16'h8A50, 16'h0);
    run_cmd("R6 write B", 3'd2, 8'h00, 8'h3C, 2'b00, 1'b1, 1, 16'h43C0, 16'h0);
    run_cmd("R6 stage B", 3'd3, 8'h00, 8'hFF, 2'b00, 1'b0, 1, 16'h1FF0, 16'h0);
    run_cmd("R6 write A max", 3'd1, 8'hFF, 8'h00, 2'b00, 1'b1, 1, 16'hCFF0, 16'h0);
  endtask

  task automatic t_update;
    run_cmd("R7 R12 update fast", 3'd4, 8'h12, 8'hE7, 2'b00, 1'b1, 2, 16'h5E70, 16'hC120);
    run_cmd("R7 update slow", 3'd4, 8'h80, 8'h01, 2'b00, 1'b0, 2, 16'h1010, 16'h8800);
  endtask

  task automatic t_power;
    run_cmd("R8 power down slow", 3'd5, 8'hFF, 8'hFF, 2'b11, 1'b0, 1, 16'h2000, 16'h0);
    run_cmd("R8 R12 power down fast", 3'd5, 8'h00, 8'h00, 2'b00, 1'b1, 1, 16'h6000, 16'h0);
  endtask

  task automatic t_unknown;
    int f0 = n_csfall;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd6;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(done == 1'b1, "R11 done after accept", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single pulse", done, 0);
    repeat (3 * HALF) @(negedge clk);
    chk(n_csfall == f0, "R11 no frame", n_csfall - f0, 0);
  endtask

  task automatic t_busy;
    int base = nfr;
    int d0 = ndone;
    bit saw_ready = 0;
    issue(3'd1, 8'h5A, 8'h00, 2'b00, 1'b0);
    cmd_op = 3'd2; code_b = 8'h77; cmd_valid = 1'b1;
    repeat (40) begin @(negedge clk); if (cmd_ready) saw_ready = 1; end
    cmd_valid = 1'b0;
    chk(!saw_ready, "R9 ready low while busy", saw_ready, 0);
    while (!done) @(negedge clk);
    chk(!cmd_ready && busy, "R9 ready low in recovery gap", cmd_ready, 0);
    wait_done(d0);
    chk(nfr - base == 1, "R9 busy request ignored", nfr - base, 1);
    chk(fr_word[base] == 16'h85A0, "R9 frame unchanged", fr_word[base], 16'h85A0);
  endtask

  task automatic t_timing;
    int mr = 1000000, ms = 1000000, mh = 1000000;
    for (int i = 0; i < nfr && i < 64; i++) begin
      if (fr_minrun[i] < mr) mr = fr_minrun[i];
      if (fr_setup[i] < ms) ms = fr_setup[i];
      if (fr_hold[i] < mh) mh = fr_hold[i];
    end
    chk(mr == HALF, "R3 sclk phase length", mr, HALF);
    chk(ms >= HALF, "R3 cs setup", ms, HALF);
    chk(mh >= HALF, "R3 cs hold after last fall", mh, HALF);
    chk(cs_n && sclk, "R1 idle after traffic", {cs_n, sclk}, 2'b11);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_ref();
    t_writes();
    t_update();
    t_power();
    t_unknown();
    t_busy();
    t_timing();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule